// File: doc/BRIEF.md
# Piezo Beeper Tone Sequencer

The block drives the two terminals of an external piezoelectric sounder with a complementary square wave. It runs entirely on a free-running 32,768 Hz clock, which keeps it independent of any system clock changes. Two tone slots, A and B, each hold a half-period divisor and a duration. One start command either plays tone A once (pulse mode) or plays A then B as a pair (sequence mode). A sequence repeats the pair a set number of times, or without end until a stop command arrives.

Four sticky event flags report progress to software: tone started, tone ended, playback finished, and last pair begun. Software clears a flag by writing one to it. The configuration is captured when a start command is accepted. Configuration changes made during playback therefore have no effect until the next start.

The finite-state machine has three states. IDLE is silent. TONE_A and TONE_B are the two tone slots. The named transitions are:
- LAUNCH: IDLE to TONE_A when start is seen.
- A_TO_B: TONE_A to TONE_B when A ends in sequence mode.
- A_FINISH: TONE_A to IDLE when A ends in pulse mode.
- NEXT_PAIR: TONE_B to TONE_A when B ends and pairs remain, or when the repeat count means forever.
- B_FINISH: TONE_B to IDLE when B ends the last pair.
- ABORT: TONE_A or TONE_B to IDLE when stop is seen.

Top module: `beep_seq`

## Requirements
- R1: During and after reset, `busy` is 0, `flags` is 0, and both `pz_p` and `pz_n` are 0. Whenever `busy` is 0, both outputs are 0.
- R2: A tone with nonzero divisor N starts on the clock after its state is entered. `pz_p` is high for the first N cycles of the tone and then toggles every N cycles. `pz_n` is always the complement of `pz_p` while the tone sounds.
- R3: A tone with divisor 0 is a rest: `busy` is 1 and both outputs stay 0 for the tone's whole duration.
- R4: A tone with duration D lasts exactly D×128 clock cycles. A duration of 0 is treated as 1.
- R5: When `seq_mode` is 0, start plays tone A once and the block then returns to idle.
- R6: When `seq_mode` is 1 and `seq_count` is C (1 to 254), the block plays A then B, C times, and then returns to idle.
- R7: A `seq_count` of 0 or 255 repeats the A/B pair until stop.
- R8: The flag bits are: bit 0 tone start, bit 1 tone end, bit 2 playback finished, and bit 3 last pair begun. Each flag is set on the edge of its event and reads as 1 from the next cycle. Bit 0 is set on every tone entry. Bit 1 is set on every tone that completes its duration. Bit 2 is set on every return to idle.
- R9: In a counted sequence, bit 3 is set when the final pair's tone A begins, and not before.
- R10: Flags are sticky. A 1 in bit k of `flag_clr` clears flag k on the next edge. A flag set on the same edge as its clear stays set.
- R11: `stop` while busy makes the block idle, with both outputs low, on the next cycle, and sets flag bit 2 without setting bit 1. `stop` while idle has no effect.
- R12: `start` while busy is ignored. Playback continues with the captured configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32,768 Hz free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin playback (accepted in idle only) |
| stop | input | 1 | Abort playback |
| seq_mode | input | 1 | 0 = pulse of tone A, 1 = A/B sequence |
| seq_count | input | 8 | Pair repeat count; 0 or 255 = forever |
| div_a | input | 7 | Tone A half-period in clocks; 0 = rest |
| dur_a | input | 8 | Tone A duration in 128-cycle units |
| div_b | input | 7 | Tone B half-period in clocks; 0 = rest |
| dur_b | input | 8 | Tone B duration in 128-cycle units |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| busy | output | 1 | Playback in progress |
| flags | output | 4 | Sticky event flags |
| pz_p | output | 1 | Piezo terminal, true phase |
| pz_n | output | 1 | Piezo terminal, inverted phase |

## Verification
Start, stop and flag clears take effect on the first rising edge after they are sampled, so `busy`, `flags` and the piezo outputs show the result one cycle later. A tone ends exactly D×128 cycles after it was entered, and the wave's phase changes every N cycles counted from tone entry. The bench drives every input on falling edges. It advances a behavioural model on rising edges and compares all outputs against the model on each falling edge, so every comparison sees values settled from the preceding edge. The directed checks count busy cycles and sample flags at the instants those latencies predict.

// File: rtl/beep_pkg.sv
package beep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TONE_A = 2'd1,
        ST_TONE_B = 2'd2
    } beep_state_e;

    localparam int FLAG_W    = 4;
    localparam int FL_START  = 0;
    localparam int FL_END    = 1;
    localparam int FL_DONE   = 2;
    localparam int FL_NEAR   = 3;
endpackage

// File: rtl/beep_tone.sv
// Half-period divider: phase starts high on restart, flips every DIV cycles.
module beep_tone #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             enable,
    input  logic [DIV_W-1:0] div,
    output logic             wave
);
    logic [DIV_W-1:0] cnt;
    logic             phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b1;
        end else if (restart) begin
            cnt   <= '0;
            phase <= 1'b1;
        end else if (enable) begin
            if (cnt == div - DIV_W'(1)) begin
                cnt   <= '0;
                phase <= ~phase;
            end else begin
                cnt <= cnt + DIV_W'(1);
            end
        end
    end

    assign wave = phase;
endmodule

// File: rtl/beep_dur.sv
// Duration timer: prescaler of TICKS cycles per unit, unit counter vs duration.
module beep_dur #(
    parameter int TICKS = 128,
    parameter int DUR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             enable,
    input  logic [DUR_W-1:0] dur,
    output logic             done
);
    localparam int PRE_W = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [PRE_W-1:0] pre;
    logic [DUR_W-1:0] units;
    logic [DUR_W-1:0] dur_eff;
    logic             unit_wrap;

    assign dur_eff   = (dur == '0) ? DUR_W'(1) : dur;
    assign unit_wrap = (pre == PRE_W'(TICKS - 1));
    assign done      = enable && unit_wrap && (units == dur_eff - DUR_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre   <= '0;
            units <= '0;
        end else if (restart) begin
            pre   <= '0;
            units <= '0;
        end else if (enable) begin
            if (unit_wrap) begin
                pre   <= '0;
                units <= units + DUR_W'(1);
            end else begin
                pre <= pre + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/beep_seq.sv
module beep_seq #(
    parameter int DIV_W = 7,
    parameter int DUR_W = 8,
    parameter int CNT_W = 8,
    parameter int TICKS = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             seq_mode,
    input  logic [CNT_W-1:0] seq_count,
    input  logic [DIV_W-1:0] div_a,
    input  logic [DUR_W-1:0] dur_a,
    input  logic [DIV_W-1:0] div_b,
    input  logic [DUR_W-1:0] dur_b,
    input  logic [3:0]       flag_clr,
    output logic             busy,
    output logic [3:0]       flags,
    output logic             pz_p,
    output logic             pz_n
);
    import beep_pkg::*;

    beep_state_e      st, st_nxt;
    logic             tone_start, load, pair_dec, tone_done, wave;
    logic [FLAG_W-1:0] flag_set;

    logic [DIV_W-1:0] cfg_div_a, cfg_div_b, cur_div;
    logic [DUR_W-1:0] cfg_dur_a, cfg_dur_b, cur_dur;
    logic             cfg_seq, cfg_forever;
    logic [CNT_W-1:0] pairs_left;
    logic             req_forever;

    assign req_forever = (seq_count == '0) || (seq_count == '1);
    assign cur_div     = (st == ST_TONE_B) ? cfg_div_b : cfg_div_a;
    assign cur_dur     = (st == ST_TONE_B) ? cfg_dur_b : cfg_dur_a;

    beep_tone #(.DIV_W(DIV_W)) u_tone (
        .clk(clk), .rst_n(rst_n), .restart(tone_start),
        .enable(busy), .div(cur_div), .wave(wave)
    );

    beep_dur #(.TICKS(TICKS), .DUR_W(DUR_W)) u_dur (
        .clk(clk), .rst_n(rst_n), .restart(tone_start),
        .enable(busy), .dur(cur_dur), .done(tone_done)
    );

    // Next-state and event decode
    always_comb begin
        st_nxt     = st;
        tone_start = 1'b0;
        load       = 1'b0;
        pair_dec   = 1'b0;
        flag_set   = '0;
        unique case (st)
            ST_IDLE: begin
                if (start) begin                       // LAUNCH
                    st_nxt             = ST_TONE_A;
                    tone_start         = 1'b1;
                    load               = 1'b1;
                    flag_set[FL_START] = 1'b1;
                    if (seq_mode && !req_forever && seq_count == CNT_W'(1))
                        flag_set[FL_NEAR] = 1'b1;
                end
            end
            ST_TONE_A: begin
                if (stop) begin                        // ABORT
                    st_nxt            = ST_IDLE;
                    flag_set[FL_DONE] = 1'b1;
                end else if (tone_done) begin
                    flag_set[FL_END] = 1'b1;
                    if (cfg_seq) begin                 // A_TO_B
                        st_nxt             = ST_TONE_B;
                        tone_start         = 1'b1;
                        flag_set[FL_START] = 1'b1;
                    end else begin                     // A_FINISH
                        st_nxt            = ST_IDLE;
                        flag_set[FL_DONE] = 1'b1;
                    end
                end
            end
            ST_TONE_B: begin
                if (stop) begin                        // ABORT
                    st_nxt            = ST_IDLE;
                    flag_set[FL_DONE] = 1'b1;
                end else if (tone_done) begin
                    flag_set[FL_END] = 1'b1;
                    if (!cfg_forever && pairs_left == CNT_W'(1)) begin // B_FINISH
                        st_nxt            = ST_IDLE;
                        flag_set[FL_DONE] = 1'b1;
                    end else begin                     // NEXT_PAIR
                        st_nxt             = ST_TONE_A;
                        tone_start         = 1'b1;
                        flag_set[FL_START] = 1'b1;
                        if (!cfg_forever) begin
                            pair_dec = 1'b1;
                            if (pairs_left == CNT_W'(2))
                                flag_set[FL_NEAR] = 1'b1;
                        end
                    end
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Captured configuration, pair counter and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_div_a   <= '0;
            cfg_div_b   <= '0;
            cfg_dur_a   <= '0;
            cfg_dur_b   <= '0;
            cfg_seq     <= 1'b0;
            cfg_forever <= 1'b0;
            pairs_left  <= '0;
            flags       <= '0;
        end else begin
            if (load) begin
                cfg_div_a   <= div_a;
                cfg_div_b   <= div_b;
                cfg_dur_a   <= dur_a;
                cfg_dur_b   <= dur_b;
                cfg_seq     <= seq_mode;
                cfg_forever <= req_forever;
                pairs_left  <= seq_count;
            end else if (pair_dec) begin
                pairs_left <= pairs_left - CNT_W'(1);
            end
            flags <= (flags & ~flag_clr) | flag_set;
        end
    end

    // Outputs
    always_comb begin
        busy = (st != ST_IDLE);
        pz_p = busy && (cur_div != '0) && wave;
        pz_n = busy && (cur_div != '0) && !wave;
    end
endmodule

// File: rtl/beep_seq_chk.sv
module beep_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       stop,
    input logic [3:0] flag_clr,
    input logic       busy,
    input logic [3:0] flags,
    input logic       pz_p,
    input logic       pz_n
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pz_p && !pz_n)) else $error("idle output"); // R1

    AST_NO_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(pz_p && pz_n)) else $error("both terminals high"); // R2

    AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && flags[0])) else $error("launch"); // R8

    AST_STOP_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && busy) |=> (!busy && !pz_p && !pz_n && flags[2])) else $error("stop"); // R11

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((~flags & $past(flags) & ~$past(flag_clr)) == 4'b0)) else $error("flag lost"); // R10
endmodule

bind beep_seq beep_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .flag_clr(flag_clr),
    .busy(busy), .flags(flags), .pz_p(pz_p), .pz_n(pz_n)
);

// File: tb/beep_seq_tb.sv
module beep_seq_tb;
    localparam int U = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, stop = 1'b0, seq_mode = 1'b0;
    logic [7:0] seq_count = '0;
    logic [6:0] div_a = '0, div_b = '0;
    logic [7:0] dur_a = '0, dur_b = '0;
    logic [3:0] flag_clr = '0;
    logic       busy, pz_p, pz_n;
    logic [3:0] flags;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    beep_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .seq_mode(seq_mode),
        .seq_count(seq_count), .div_a(div_a), .dur_a(dur_a), .div_b(div_b),
        .dur_b(dur_b), .flag_clr(flag_clr), .busy(busy), .flags(flags),
        .pz_p(pz_p), .pz_n(pz_n)
    );

    // Behavioural reference model
    int m_st, m_el, m_left, m_da, m_db, m_ua, m_ub;
    bit m_seq, m_fv;
    logic [3:0] m_flags;

    always @(posedge clk) begin
        int d; logic [3:0] s;
        s = 4'b0;
        if (!rst_n) begin
            m_st = 0; m_el = 0; m_left = 0; m_flags = 4'b0;
        end else begin
            if (m_st == 0) begin
                if (start) begin
                    m_da = div_a; m_db = div_b; m_ua = dur_a; m_ub = dur_b;
                    m_seq = seq_mode; m_left = seq_count;
                    m_fv = (seq_count == 0 || seq_count == 255);
                    m_st = 1; m_el = 0; s[0] = 1;
                    if (m_seq && !m_fv && m_left == 1) s[3] = 1;
                end
            end else if (stop) begin
                m_st = 0; s[2] = 1;
            end else begin
                d = (m_st == 1) ? m_ua : m_ub;
                if (d == 0) d = 1;
                if (m_el == d * U - 1) begin
                    s[1] = 1; m_el = 0;
                    if (m_st == 1) begin
                        if (m_seq) begin m_st = 2; s[0] = 1; end
                        else begin m_st = 0; s[2] = 1; end
                    end else if (!m_fv && m_left == 1) begin
                        m_st = 0; s[2] = 1;
                    end else begin
                        m_st = 1; s[0] = 1;
                        if (!m_fv) begin
                            m_left = m_left - 1;
                            if (m_left == 1) s[3] = 1;
                        end
                    end
                end else begin
                    m_el = m_el + 1;
                end
            end
            m_flags = (m_flags & ~flag_clr) | s;
        end
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        int dv; bit e_p, e_n;
        cyc++;
        if (rst_n && !finished) begin
            dv = (m_st == 2) ? m_db : m_da;
            e_p = (m_st != 0) && dv != 0 && ((m_el / dv) % 2 == 0);
            e_n = (m_st != 0) && dv != 0 && !e_p;
            chk("R2 pz_p", pz_p, e_p);
            chk("R2 pz_n", pz_n, e_n);
            chk("R4 busy", busy, m_st != 0);
            chk("R8 flags", flags, m_flags);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic clear_all();
        @(negedge clk); flag_clr = 4'hF;
        @(negedge clk); flag_clr = 4'h0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset flags", flags, 0);
        chk("R1 reset pz", {pz_p, pz_n}, 0);
        rst_n = 1;
        @(negedge clk);

        // Pulse mode
        seq_mode = 0; div_a = 2; dur_a = 1; div_b = 9; dur_b = 3;
        busy_len(n);
        chk("R5 pulse length", n, U);
        chk("R8 pulse flags", flags, 4'b0111);
        chk("R1 idle pz", {pz_p, pz_n}, 0);
        clear_all();
        chk("R10 cleared", flags, 0);

        // Zero duration and rest
        div_a = 0; dur_a = 0;
        pulse_start();
        repeat (20) @(negedge clk);
        chk("R3 rest busy", busy, 1);
        chk("R3 rest quiet", {pz_p, pz_n}, 0);
        while (busy) @(negedge clk);
        chk("R4 dur0 ended", busy, 0);
        clear_all();

        // Counted sequence of two pairs
        seq_mode = 1; seq_count = 2; div_a = 3; dur_a = 1; div_b = 5; dur_b = 2;
        pulse_start();
        repeat (200) @(negedge clk);
        chk("R9 near not early", flags[3], 0);
        chk("R2 tone pair phase", pz_p ^ pz_n, 1);
        while (busy) @(negedge clk);
        chk("R6 seq flags", flags, 4'b1111);
        clear_all();
        busy_len(n);
        chk("R6 seq length", n, 2 * 3 * U);
        clear_all();

        // Single pair: near at launch; set wins over clear
        seq_count = 1;
        @(negedge clk); start = 1; flag_clr = 4'hF;
        @(negedge clk); start = 0; flag_clr = 4'h0;
        chk("R9 near at launch", flags[3], 1);
        chk("R10 set beats clear", flags[0], 1);
        while (busy) @(negedge clk);
        clear_all();

        // Forever with count 0, start ignored while busy, then stop
        seq_count = 0; dur_b = 1;
        pulse_start();
        repeat (100) @(negedge clk);
        div_a = 7; dur_a = 9;
        pulse_start();
        chk("R12 start ignored", busy, 1);
        repeat (1500) @(negedge clk);
        chk("R7 forever busy", busy, 1);
        chk("R7 no done", flags[2], 0);
        clear_all();
        @(negedge clk); stop = 1;
        @(negedge clk); stop = 0;
        chk("R11 stop idle", busy, 0);
        chk("R11 stop quiet", {pz_p, pz_n}, 0);
        chk("R11 stop flags", flags[2:1], 2'b10);
        clear_all();
        @(negedge clk); stop = 1;
        @(negedge clk); stop = 0;
        chk("R11 stop idle no effect", flags, 0);

        // Forever with count 255
        seq_count = 255; div_a = 2; dur_a = 1;
        pulse_start();
        repeat (1200) @(negedge clk);
        chk("R7 count255 busy", busy, 1);
        chk("R9 no near forever", flags[3], 0);
        @(negedge clk); stop = 1;
        @(negedge clk); stop = 0;
        chk("R11 stop 255", busy, 0);
        repeat (4) @(negedge clk);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule